// File: doc/BRIEF.md
# Pulse Width and Period Capture

This block measures how long an input signal spends high and how long it spends low. Both lengths are counted in ticks of the block clock. Before it is measured, the raw input is brought into the clock domain and cleaned by a debouncer. The debouncer accepts a new level only after the input has held that level for a programmed number of samples. Because it delays rising and falling changes by the same number of cycles, the durations it passes on are exact.

In half-period mode the block measures only the high phase, from a rising edge to the following falling edge. In full-period mode it measures a whole period: the high time goes to one capture register and the low time to another. The edge that opens each period is selectable. A programmed period count makes the block add up the results of several consecutive periods into one report. This helps when the signal is too fast to read every period.

Each report updates both capture registers and raises a one-cycle done pulse. By default measurement runs continuously. When trigger mode is selected, one measurement is made per trigger pulse.

Top module: `phase_meter`

## Requirements
- R1: A level change of `sig_in` is accepted only after the synchronized input has differed from the accepted level for `stab_cycles`+1 consecutive samples. A pulse of `stab_cycles` cycles or fewer has no effect on the results. Rising and falling changes are delayed by the same amount, so measured durations equal the raw durations.
- R2: When `full_mode`=0, measurement opens at a rising edge and closes at the falling edge. `cap_hi` receives the high time in ticks and `cap_lo` is written with 0.
- R3: When `full_mode`=1 and `fall_start`=0, a period runs from one rising edge to the next. `cap_hi` receives its high ticks and `cap_lo` its low ticks.
- R4: When `full_mode`=1 and `fall_start`=1, a period runs from one falling edge to the next, so the low phase comes first. `cap_hi` and `cap_lo` still hold high and low ticks.
- R5: The high and low totals are summed over `n_periods` consecutive periods before one report is made. A `n_periods` value of 0 is treated as 1.
- R6: An accumulator that would pass the largest value of a `CAP_W`-bit number stays at that value. `ovf`, updated with each report, is 1 if the reported result saturated and 0 otherwise.
- R7: `done` is high for exactly one cycle, in the cycle where `cap_hi`, `cap_lo` and `ovf` take new values. The captures do not change at any other time.
- R8: In full mode without trigger wait, the edge that closes a report also opens the next measurement, so no period is skipped. In half mode the next measurement opens at the next rising edge.
- R9: When `trig_wait`=1, a measurement begins only after a one-cycle pulse on `trig`. After each report the block waits for a new trigger.
- R10: While `arm`=0 the block makes no report, and any partial sums are discarded. After re-arming, counting starts afresh at the next opening edge.
- R11: After reset `cap_hi`, `cap_lo`, `done` and `ovf` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; one tick of every measured duration |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | 1 | Raw, asynchronous signal to be measured |
| stab_cycles | input | DB_W | Extra stable samples required before a level is accepted |
| full_mode | input | 1 | 0 = high phase only, 1 = full period |
| fall_start | input | 1 | In full mode, 1 = periods open at falling edges |
| n_periods | input | PC_W | Periods summed per report (0 means 1) |
| trig_wait | input | 1 | 1 = one measurement per trigger pulse |
| trig | input | 1 | Trigger pulse, one clock wide |
| arm | input | 1 | Measurement enable; low aborts and idles |
| cap_hi | output | CAP_W | Reported high-phase total in ticks |
| cap_lo | output | CAP_W | Reported low-phase total in ticks (0 in half mode) |
| done | output | 1 | One-cycle pulse when a report is written |
| ovf | output | 1 | Set when the reported result saturated |

## Verification
A fault in the internal sequencing appears at the ports within one input period. A wrong period counter or edge selection shows as a missing, extra or early `done`, or as capture totals that span the wrong edges. A fault in an accumulator or in the debouncer count shows at the next report as a capture value that is off by a fixed number of ticks or includes a rejected spike. The tests therefore use phase lengths that are all different and periods summed in order, so any misplaced boundary changes a reported number.

// File: rtl/phm_pkg.sv
package phm_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SEEK,
    ST_MEAS
  } phm_state_e;

  // command to both phase accumulators
  typedef struct packed {
    logic clr;   // zero value and saturation flag
    logic seed;  // restart: value = 1 if this phase is current, else 0
    logic inc;   // add one tick if this phase is current
  } acc_op_t;

endpackage

// File: rtl/phm_sync_debounce.sv
module phm_sync_debounce #(
  parameter int SYNC_STAGES = 2,
  parameter int DB_W        = 16
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            raw,
  input  logic [DB_W-1:0] stab,
  output logic            sync_o,
  output logic            deb_o
);

  logic [DB_W-1:0] run_cnt;

  generate
    if (SYNC_STAGES < 2) begin : g_one
      logic s_q;
      always_ff @(posedge clk) begin
        if (rst) s_q <= 1'b0;
        else     s_q <= raw;
      end
      assign sync_o = s_q;
    end else begin : g_chain
      logic [SYNC_STAGES-1:0] s_q;
      always_ff @(posedge clk) begin
        if (rst) s_q <= '0;
        else     s_q <= {s_q[SYNC_STAGES-2:0], raw};
      end
      assign sync_o = s_q[SYNC_STAGES-1];
    end
  endgenerate

  // a differing sample must repeat stab+1 times in a row
  always_ff @(posedge clk) begin
    if (rst) begin
      deb_o   <= 1'b0;
      run_cnt <= '0;
    end else if (sync_o != deb_o) begin
      if (run_cnt == stab) begin
        deb_o   <= sync_o;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end else begin
      run_cnt <= '0;
    end
  end

endmodule

// File: rtl/phm_edge.sv
module phm_edge (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic rise,
  output logic fall
);

  logic lvl_q;

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl;
  end

  assign rise = lvl & ~lvl_q;
  assign fall = ~lvl & lvl_q;

endmodule

// File: rtl/phm_accum.sv
module phm_accum
  import phm_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  acc_op_t      op,
  input  logic         hit,
  output logic [W-1:0] val,
  output logic         sat
);

  always_ff @(posedge clk) begin
    if (rst || op.clr) begin
      val <= '0;
      sat <= 1'b0;
    end else if (op.seed) begin
      val <= W'(hit);
      sat <= 1'b0;
    end else if (op.inc && hit) begin
      if (&val) sat <= 1'b1;
      else      val <= val + 1'b1;
    end
  end

endmodule

// File: rtl/phm_ctrl.sv
module phm_ctrl
  import phm_pkg::*;
#(
  parameter int CAP_W = 32,
  parameter int PC_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             arm,
  input  logic             trig,
  input  logic             trig_wait,
  input  logic             full_mode,
  input  logic             fall_start,
  input  logic [PC_W-1:0]  n_periods,
  input  logic             rise,
  input  logic             fall,
  input  logic [CAP_W-1:0] hi_val,
  input  logic [CAP_W-1:0] lo_val,
  input  logic             hi_sat,
  input  logic             lo_sat,
  output acc_op_t          op,
  output logic [CAP_W-1:0] cap_hi,
  output logic [CAP_W-1:0] cap_lo,
  output logic             done,
  output logic             ovf
);

  phm_state_e      st, st_n;
  logic [PC_W-1:0] pc, pc_n, pc_inc, tgt;
  logic            open_e, close_e, last, fin;

  assign open_e  = full_mode ? (fall_start ? fall : rise) : rise;
  assign close_e = full_mode ? open_e : fall;
  assign tgt     = (n_periods == '0) ? PC_W'(1) : n_periods;
  assign pc_inc  = pc + 1'b1;
  assign last    = (pc_inc >= tgt);

  always_comb begin
    op   = '0;
    st_n = st;
    pc_n = pc;
    fin  = 1'b0;
    if (!arm) begin
      st_n   = ST_IDLE;
      op.clr = 1'b1;
      pc_n   = '0;
    end else begin
      case (st)
        ST_IDLE: begin
          op.clr = 1'b1;
          pc_n   = '0;
          if (!trig_wait || trig) st_n = ST_SEEK;
        end
        ST_SEEK: begin
          if (open_e) begin
            op.seed = 1'b1;
            pc_n    = '0;
            st_n    = ST_MEAS;
          end
        end
        ST_MEAS: begin
          if (close_e && last) begin
            fin  = 1'b1;
            pc_n = '0;
            if (trig_wait) begin
              st_n   = ST_IDLE;
              op.clr = 1'b1;
            end else if (full_mode) begin
              op.seed = 1'b1;
            end else begin
              st_n   = ST_SEEK;
              op.clr = 1'b1;
            end
          end else begin
            op.inc = 1'b1;
            if (close_e) pc_n = pc_inc;
          end
        end
        default: st_n = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      pc     <= '0;
      cap_hi <= '0;
      cap_lo <= '0;
      done   <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      st   <= st_n;
      pc   <= pc_n;
      done <= fin;
      if (fin) begin
        cap_hi <= hi_val;
        cap_lo <= full_mode ? lo_val : '0;
        ovf    <= hi_sat | (full_mode & lo_sat);
      end
    end
  end

endmodule

// File: rtl/phase_meter.sv
module phase_meter
  import phm_pkg::*;
#(
  parameter int CAP_W       = 32,
  parameter int DB_W        = 16,
  parameter int PC_W        = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sig_in,
  input  logic [DB_W-1:0]  stab_cycles,
  input  logic             full_mode,
  input  logic             fall_start,
  input  logic [PC_W-1:0]  n_periods,
  input  logic             trig_wait,
  input  logic             trig,
  input  logic             arm,
  output logic [CAP_W-1:0] cap_hi,
  output logic [CAP_W-1:0] cap_lo,
  output logic             done,
  output logic             ovf
);

  localparam int N_PH = 2;  // index 0 = high phase, 1 = low phase

  logic             sync_lvl, deb_lvl, rise, fall;
  acc_op_t          op;
  logic [CAP_W-1:0] acc_val [N_PH];
  logic             acc_sat [N_PH];

  phm_sync_debounce #(.SYNC_STAGES(SYNC_STAGES), .DB_W(DB_W)) u_deb (
    .clk(clk), .rst(rst), .raw(sig_in), .stab(stab_cycles),
    .sync_o(sync_lvl), .deb_o(deb_lvl)
  );

  phm_edge u_edge (
    .clk(clk), .rst(rst), .lvl(deb_lvl), .rise(rise), .fall(fall)
  );

  generate
    for (genvar g = 0; g < N_PH; g++) begin : g_acc
      logic hit;
      assign hit = (g == 0) ? deb_lvl : ~deb_lvl;
      phm_accum #(.W(CAP_W)) u_acc (
        .clk(clk), .rst(rst), .op(op), .hit(hit),
        .val(acc_val[g]), .sat(acc_sat[g])
      );
    end
  endgenerate

  phm_ctrl #(.CAP_W(CAP_W), .PC_W(PC_W)) u_ctrl (
    .clk(clk), .rst(rst), .arm(arm), .trig(trig), .trig_wait(trig_wait),
    .full_mode(full_mode), .fall_start(fall_start), .n_periods(n_periods),
    .rise(rise), .fall(fall),
    .hi_val(acc_val[0]), .lo_val(acc_val[1]),
    .hi_sat(acc_sat[0]), .lo_sat(acc_sat[1]),
    .op(op), .cap_hi(cap_hi), .cap_lo(cap_lo), .done(done), .ovf(ovf)
  );

endmodule

// File: rtl/phase_meter_chk.sv
module phase_meter_chk #(
  parameter int CAP_W = 32
) (
  input logic             clk,
  input logic             rst,
  input logic             arm,
  input logic             full_mode,
  input logic             sync_lvl,
  input logic             deb_lvl,
  input logic [CAP_W-1:0] cap_hi,
  input logic [CAP_W-1:0] cap_lo,
  input logic             done,
  input logic             ovf
);

  // R1: an accepted change always takes the synchronized input level
  a_r1_deb_takes_input: assert property (@(posedge clk) disable iff (rst)
    (deb_lvl != $past(deb_lvl)) |-> (deb_lvl == $past(sync_lvl)));

  // R2: half mode reports a zero low total
  a_r2_half_lo_zero: assert property (@(posedge clk) disable iff (rst)
    (done && !$past(full_mode)) |-> (cap_lo == '0));

  // R6: an overflow report carries a pinned total
  a_r6_ovf_pinned: assert property (@(posedge clk) disable iff (rst)
    (done && ovf) |-> ((&cap_hi) || (&cap_lo)));

  // R7: done lasts a single cycle
  a_r7_done_one_cycle: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R7: captures move only together with done
  a_r7_caps_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(cap_hi) && $stable(cap_lo)));

  // R10: disarmed block reports nothing
  a_r10_disarm_quiet: assert property (@(posedge clk) disable iff (rst)
    !arm |=> !done);

endmodule

bind phase_meter phase_meter_chk #(.CAP_W(CAP_W)) u_chk (
  .clk(clk), .rst(rst), .arm(arm), .full_mode(full_mode),
  .sync_lvl(sync_lvl), .deb_lvl(deb_lvl),
  .cap_hi(cap_hi), .cap_lo(cap_lo), .done(done), .ovf(ovf)
);

// File: tb/phase_meter_tb.sv
module phase_meter_tb;

  localparam int CAP_W = 32;
  localparam int SMW   = 6;
  localparam int DB_W  = 16;
  localparam int PC_W  = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sig_in = 1'b0;
  logic [DB_W-1:0] stab_cycles = '0;
  logic full_mode = 1'b0, fall_start = 1'b0, trig_wait = 1'b0, trig = 1'b0, arm = 1'b0;
  logic [PC_W-1:0] n_periods = '0;
  logic [CAP_W-1:0] cap_hi, cap_lo;
  logic done, ovf;
  logic [SMW-1:0] s_hi, s_lo;
  logic s_done, s_ovf;

  int checks = 0, errors = 0;
  int tot_done = 0, s_tot = 0, dbl = 0, base = 0, sbase = 0;
  longint last_hi = 0, last_lo = 0, last_ovf = 0;
  longint sl_hi = 0, sl_lo = 0, sl_ovf = 0;
  bit prev_done = 1'b0;
  bit ended = 1'b0;

  always #2.5 clk = ~clk;

  phase_meter #(.CAP_W(CAP_W), .DB_W(DB_W), .PC_W(PC_W)) u_dut (
    .clk(clk), .rst(rst), .sig_in(sig_in), .stab_cycles(stab_cycles),
    .full_mode(full_mode), .fall_start(fall_start), .n_periods(n_periods),
    .trig_wait(trig_wait), .trig(trig), .arm(arm),
    .cap_hi(cap_hi), .cap_lo(cap_lo), .done(done), .ovf(ovf)
  );

  phase_meter #(.CAP_W(SMW), .DB_W(DB_W), .PC_W(PC_W)) u_dut_small (
    .clk(clk), .rst(rst), .sig_in(sig_in), .stab_cycles(stab_cycles),
    .full_mode(full_mode), .fall_start(fall_start), .n_periods(n_periods),
    .trig_wait(trig_wait), .trig(trig), .arm(arm),
    .cap_hi(s_hi), .cap_lo(s_lo), .done(s_done), .ovf(s_ovf)
  );

  // sample outputs away from the active edge
  always @(negedge clk) begin
    if (!rst) begin
      if (done) begin
        tot_done = tot_done + 1;
        last_hi  = cap_hi;
        last_lo  = cap_lo;
        last_ovf = ovf;
        if (prev_done) dbl = dbl + 1;
      end
      prev_done = done;
      if (s_done) begin
        s_tot  = s_tot + 1;
        sl_hi  = s_hi;
        sl_lo  = s_lo;
        sl_ovf = s_ovf;
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic lvl(input bit v, input int n);
    sig_in = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic setup(input bit fm, input bit fs, input int np, input int sd, input bit tw);
    @(negedge clk);
    arm = 1'b0; trig = 1'b0; sig_in = 1'b0;
    repeat (40) @(negedge clk);
    full_mode = fm; fall_start = fs; n_periods = PC_W'(np);
    stab_cycles = DB_W'(sd); trig_wait = tw;
    base = tot_done; sbase = s_tot;
    arm = 1'b1;
  endtask

  task automatic t_reset;
    chk("R11 cap_hi", cap_hi, 0);
    chk("R11 cap_lo", cap_lo, 0);
    chk("R11 done", done, 0);
    chk("R11 ovf", ovf, 0);
  endtask

  task automatic t_half;
    setup(0, 0, 1, 0, 0);
    lvl(0, 10); lvl(1, 12); lvl(0, 25); lvl(1, 12); lvl(0, 25);
    chk("R8 half reports", tot_done - base, 2);
    chk("R2 half hi", last_hi, 12);
    chk("R2 half lo", last_lo, 0);
  endtask

  task automatic t_full_rise;
    setup(1, 0, 1, 0, 0);
    lvl(0, 10); lvl(1, 7); lvl(0, 9); lvl(1, 7); lvl(0, 9); lvl(1, 7); lvl(0, 20);
    chk("R8 back-to-back reports", tot_done - base, 2);
    chk("R3 full hi", last_hi, 7);
    chk("R3 full lo", last_lo, 9);
    chk("R6 no ovf", last_ovf, 0);
  endtask

  task automatic t_full_fall;
    setup(1, 1, 2, 0, 0);
    lvl(0, 10); lvl(1, 3); lvl(0, 5); lvl(1, 6); lvl(0, 7); lvl(1, 8); lvl(0, 30);
    chk("R4 fall reports", tot_done - base, 1);
    chk("R4 fall hi", last_hi, 14);
    chk("R4 fall lo", last_lo, 12);
  endtask

  task automatic t_accum;
    setup(1, 0, 3, 0, 0);
    lvl(0, 10); lvl(1, 5); lvl(0, 8); lvl(1, 6); lvl(0, 9); lvl(1, 7); lvl(0, 10);
    lvl(1, 4); lvl(0, 30);
    chk("R5 accum reports", tot_done - base, 1);
    chk("R5 accum hi", last_hi, 18);
    chk("R5 accum lo", last_lo, 27);
  endtask

  task automatic t_zero_count;
    setup(1, 0, 0, 0, 0);
    lvl(0, 10); lvl(1, 4); lvl(0, 6); lvl(1, 5); lvl(0, 30);
    chk("R5 zero count reports", tot_done - base, 1);
    chk("R5 zero count hi", last_hi, 4);
    chk("R5 zero count lo", last_lo, 6);
    chk("R6 small no ovf", sl_ovf, 0);
    chk("R6 small hi", sl_hi, 4);
  endtask

  task automatic t_ovf;
    setup(1, 0, 1, 0, 0);
    lvl(0, 10); lvl(1, 80); lvl(0, 20); lvl(1, 5); lvl(0, 30);
    chk("R6 wide hi", last_hi, 80);
    chk("R6 wide ovf", last_ovf, 0);
    chk("R6 small reports", s_tot - sbase, 1);
    chk("R6 small hi pinned", sl_hi, 63);
    chk("R6 small lo", sl_lo, 20);
    chk("R6 small ovf", sl_ovf, 1);
  endtask

  task automatic t_debounce;
    setup(1, 0, 1, 4, 0);
    lvl(0, 12); lvl(1, 8); lvl(0, 2); lvl(1, 10);
    lvl(0, 14); lvl(1, 4); lvl(0, 12); lvl(1, 6); lvl(0, 30);
    chk("R1 spikes reports", tot_done - base, 1);
    chk("R1 spikes hi", last_hi, 20);
    chk("R1 spikes lo", last_lo, 30);
    setup(1, 0, 1, 4, 0);
    lvl(0, 12); lvl(1, 20); lvl(0, 10); lvl(1, 5); lvl(0, 15); lvl(1, 6); lvl(0, 30);
    chk("R1 boundary reports", tot_done - base, 2);
    chk("R1 boundary hi", last_hi, 5);
    chk("R1 boundary lo", last_lo, 15);
  endtask

  task automatic t_trigger;
    setup(1, 0, 1, 0, 1);
    lvl(0, 10); lvl(1, 5); lvl(0, 5); lvl(1, 5); lvl(0, 10);
    chk("R9 no trigger no report", tot_done - base, 0);
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    lvl(0, 5); lvl(1, 6); lvl(0, 7); lvl(1, 3); lvl(0, 20);
    chk("R9 triggered reports", tot_done - base, 1);
    chk("R9 triggered hi", last_hi, 6);
    chk("R9 triggered lo", last_lo, 7);
    lvl(1, 4); lvl(0, 4); lvl(1, 4); lvl(0, 20);
    chk("R9 waits for new trigger", tot_done - base, 1);
  endtask

  task automatic t_arm;
    setup(1, 0, 1, 0, 0);
    arm = 1'b0;
    lvl(0, 10); lvl(1, 5); lvl(0, 5); lvl(1, 5); lvl(0, 20);
    chk("R10 disarmed no report", tot_done - base, 0);
    arm = 1'b1;
    lvl(0, 10); lvl(1, 5); lvl(0, 3);
    arm = 1'b0;
    lvl(0, 4);
    arm = 1'b1;
    lvl(0, 5); lvl(1, 6); lvl(0, 7); lvl(1, 3); lvl(0, 20);
    chk("R10 rearm reports", tot_done - base, 1);
    chk("R10 rearm hi fresh", last_hi, 6);
    chk("R10 rearm lo fresh", last_lo, 7);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_half();
    t_full_rise();
    t_full_fall();
    t_accum();
    t_zero_count();
    t_ovf();
    t_debounce();
    t_trigger();
    t_arm();
    chk("R7 done single cycle", dbl, 0);
    if (!ended) begin
      ended = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (60000) @(posedge clk);
    if (!ended) begin
      ended = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule